// File: doc/BRIEF.md
# Display PHY power-up sequencer

This block brings up the analog support circuits of a display serial link in a fixed order, driven by one start pulse from software. On start it switches on the voltage regulator and the bandgap reference together. It then polls a regulator-ready bit. Once that bit is seen, or the wait runs out, it switches on the PLL. It then polls a PLL-lock bit. Once that bit is seen, or that wait runs out, it enables the link wrapper and reports completion.

Status is sampled only once per poll interval. The interval is a programmable number of clock cycles, so one design serves real millisecond polling and short simulation runs. Each stage allows at most a fixed number of polls. When a stage runs out of polls, the sequencer sets a sticky warning flag for that stage and moves on; it does not abort. All enables stay on until a synchronous power-down input drops them together.

Top module: `phy_pwrup_seq`

## Requirements
- R1: During and right after reset, every enable, `busy_o`, `done_o` and both timeout flags are 0.
- R2: A start pulse seen while idle raises the regulator and bandgap enables together at the next clock edge. At the same edge `busy_o` rises and `done_o` and both timeout flags clear.
- R3: Status is sampled once every P cycles, where P is `poll_cycles_i` and a value of 0 acts as 1. The regulator-ready bit is bit 12 of `status_i`. The PLL enable rises at the first edge k·P after the start edge for which bit 12 was 1 in the cycle before that edge.
- R4: A status bit that is high only between polls has no effect. Bit 8 has no effect while the sequencer waits for the regulator.
- R5: The PLL-lock bit is bit 8 of `status_i`. The poll timer restarts at the edge where the PLL enable rises. The wrapper enable and `done_o` rise at the first poll of that stage that sees bit 8 high, and `busy_o` falls at the same edge.
- R6: If bit 12 is not seen within MAX_POLLS polls, the PLL enable still rises at edge MAX_POLLS·P, and `reg_timeout_o` is set at that same edge.
- R7: If bit 8 is not seen within MAX_POLLS polls, the wrapper enable and `done_o` still rise at the last poll of the stage, and `pll_timeout_o` is set at that same edge.
- R8: The timeout flags are sticky. They survive completion and power-down, and clear only at the edge that accepts the next start.
- R9: A start pulse while busy is ignored. The stage in progress and its poll timing are unchanged.
- R10: A power-down request drops all four enables and `done_o` at the next edge and returns the sequencer to idle. When power-down and start arrive in the same cycle, power-down wins.
- R11: After completion, the enables stay high until power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin power-up |
| pwr_down_i | input | 1 | Synchronous request to drop all enables |
| poll_cycles_i | input | POLL_W | Poll interval in clock cycles (0 acts as 1) |
| status_i | input | STAT_W | Status word; bit 12 regulator ready, bit 8 PLL lock |
| reg_en_o | output | 1 | Regulator enable |
| bg_en_o | output | 1 | Bandgap reference enable |
| pll_en_o | output | 1 | PLL enable |
| link_en_o | output | 1 | Link wrapper enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| reg_timeout_o | output | 1 | Sticky: regulator wait ran out |
| pll_timeout_o | output | 1 | Sticky: PLL wait ran out |

## Verification
The assertions assume that `poll_cycles_i` stays constant while a sequence runs. Under that assumption, two polls are never closer together than one interval, and the poll count cannot pass its limit. The stimulus changes the interval only while the sequencer is idle, just before a start pulse. The status bits are changed only away from the clock edge. The ordering checks assume that power-down is the only way enables fall. The bench never forces an enable in any other way.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_REG_WAIT = 2'd1,
    ST_PLL_WAIT = 2'd2
  } seqState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic startSeq;   // begin a new run
    logic pllOn;      // regulator stage finished
    logic linkOn;     // PLL stage finished
    logic regTo;      // regulator stage finished by running out of polls
    logic pllTo;      // PLL stage finished by running out of polls
    logic powerDown;  // drop every enable
    logic timerClr;   // restart poll timer and poll count
    logic counting;   // a wait stage is active
  } seqStrobe_t;

endpackage

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       pwr_down_i,
  input  logic       pollTick_i,
  input  logic       pollLast_i,
  input  logic       regRdy_i,
  input  logic       pllLock_i,
  output seqStrobe_t strobe_o,
  output logic       busy_o
);

  seqState_t state, stateNxt;
  seqStrobe_t stb;

  always_comb begin
    stateNxt      = state;
    stb           = '0;
    stb.powerDown = pwr_down_i;
    stb.counting  = (state != ST_IDLE);
    if (pwr_down_i) begin
      stateNxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            stb.startSeq = 1'b1;
            stb.timerClr = 1'b1;
            stateNxt     = ST_REG_WAIT;
          end
        end
        ST_REG_WAIT: begin
          if (pollTick_i && (regRdy_i || pollLast_i)) begin
            stb.pllOn    = 1'b1;
            stb.regTo    = !regRdy_i;
            stb.timerClr = 1'b1;
            stateNxt     = ST_PLL_WAIT;
          end
        end
        ST_PLL_WAIT: begin
          if (pollTick_i && (pllLock_i || pollLast_i)) begin
            stb.linkOn   = 1'b1;
            stb.pllTo    = !pllLock_i;
            stb.timerClr = 1'b1;
            stateNxt     = ST_IDLE;
          end
        end
        default: stateNxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNxt;
  end

  assign strobe_o = stb;
  assign busy_o   = (state != ST_IDLE);

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && start_i && !pwr_down_i && !pollTick_i) |=> (state == $past(state))); // R9

  AST_PDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (state == ST_IDLE)); // R10

endmodule

// File: rtl/pwrseq_dp.sv
module pwrseq_dp
  import pwrseq_pkg::*;
#(
  parameter int STAT_W    = 16,
  parameter int REG_BIT   = 12,
  parameter int PLL_BIT   = 8,
  parameter int POLL_W    = 16,
  parameter int MAX_POLLS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [POLL_W-1:0] pollCycles_i,
  output logic              pollTick_o,
  output logic              pollLast_o,
  output logic              regRdy_o,
  output logic              pllLock_o,
  output logic              regEn_o,
  output logic              bgEn_o,
  output logic              pllEn_o,
  output logic              linkEn_o,
  output logic              done_o,
  output logic              regTo_o,
  output logic              pllTo_o
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(MAX_POLLS - 1);

  logic [POLL_W-1:0] timer, lastTick;
  logic [CNT_W-1:0]  polls;

  assign lastTick   = (pollCycles_i == '0) ? '0 : pollCycles_i - 1'b1;
  assign pollTick_o = strobe_i.counting && (timer == lastTick);
  assign pollLast_o = (polls == LAST_POLL);
  assign regRdy_o   = status_i[REG_BIT];
  assign pllLock_o  = status_i[PLL_BIT];

  // poll interval timer and poll counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      polls <= '0;
    end else if (!strobe_i.counting || strobe_i.timerClr) begin
      timer <= '0;
      polls <= '0;
    end else begin
      timer <= (timer == lastTick) ? '0 : timer + 1'b1;
      if (pollTick_o) polls <= polls + 1'b1;
    end
  end

  // enables and completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regEn_o  <= 1'b0;
      bgEn_o   <= 1'b0;
      pllEn_o  <= 1'b0;
      linkEn_o <= 1'b0;
      done_o   <= 1'b0;
    end else if (strobe_i.powerDown) begin
      regEn_o  <= 1'b0;
      bgEn_o   <= 1'b0;
      pllEn_o  <= 1'b0;
      linkEn_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      if (strobe_i.startSeq) begin
        regEn_o <= 1'b1;
        bgEn_o  <= 1'b1;
        done_o  <= 1'b0;
      end
      if (strobe_i.pllOn) pllEn_o <= 1'b1;
      if (strobe_i.linkOn) begin
        linkEn_o <= 1'b1;
        done_o   <= 1'b1;
      end
    end
  end

  // sticky stage warnings, cleared only by a new start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regTo_o <= 1'b0;
      pllTo_o <= 1'b0;
    end else if (strobe_i.startSeq) begin
      regTo_o <= 1'b0;
      pllTo_o <= 1'b0;
    end else begin
      if (strobe_i.regTo) regTo_o <= 1'b1;
      if (strobe_i.pllTo) pllTo_o <= 1'b1;
    end
  end

  AST_PLL_AFTER_REG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pllEn_o) |-> (regEn_o && bgEn_o)); // R3

  AST_LINK_AFTER_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linkEn_o) |-> pllEn_o); // R5

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    polls < CNT_W'(MAX_POLLS)); // R6

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (pollTick_o && lastTick != '0 && !strobe_i.timerClr) |=> !pollTick_o); // R3

  AST_DONE_HOLDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (regEn_o && pllEn_o && linkEn_o)); // R11

  AST_REGTO_WITH_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regTo_o) |-> pllEn_o); // R6

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
  import pwrseq_pkg::*;
#(
  parameter int STAT_W    = 16,
  parameter int REG_BIT   = 12,
  parameter int PLL_BIT   = 8,
  parameter int POLL_W    = 16,
  parameter int MAX_POLLS = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pwr_down_i,
  input  logic [POLL_W-1:0] poll_cycles_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              reg_en_o,
  output logic              bg_en_o,
  output logic              pll_en_o,
  output logic              link_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              reg_timeout_o,
  output logic              pll_timeout_o
);

  seqStrobe_t strobe;
  logic pollTick, pollLast, regRdy, pllLock;

  pwrseq_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .pwr_down_i (pwr_down_i),
    .pollTick_i (pollTick),
    .pollLast_i (pollLast),
    .regRdy_i   (regRdy),
    .pllLock_i  (pllLock),
    .strobe_o   (strobe),
    .busy_o     (busy_o)
  );

  pwrseq_dp #(
    .STAT_W    (STAT_W),
    .REG_BIT   (REG_BIT),
    .PLL_BIT   (PLL_BIT),
    .POLL_W    (POLL_W),
    .MAX_POLLS (MAX_POLLS)
  ) dp_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_i     (strobe),
    .status_i     (status_i),
    .pollCycles_i (poll_cycles_i),
    .pollTick_o   (pollTick),
    .pollLast_o   (pollLast),
    .regRdy_o     (regRdy),
    .pllLock_o    (pllLock),
    .regEn_o      (reg_en_o),
    .bgEn_o       (bg_en_o),
    .pllEn_o      (pll_en_o),
    .linkEn_o     (link_en_o),
    .done_o       (done_o),
    .regTo_o      (reg_timeout_o),
    .pllTo_o      (pll_timeout_o)
  );

endmodule

// File: tb/phy_pwrup_seq_tb_top.sv
`timescale 1ns/1ps
module phy_pwrup_seq_tb_top;

  localparam int MAXP  = 200;
  localparam int NEVER = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pdown = 1'b0;
  logic [15:0] pollCycles = 16'd1;
  logic [15:0] status = '0;
  logic regEn, bgEn, pllEn, linkEn, busy, done, regTo, pllTo;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  phy_pwrup_seq dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .pwr_down_i    (pdown),
    .poll_cycles_i (pollCycles),
    .status_i      (status),
    .reg_en_o      (regEn),
    .bg_en_o       (bgEn),
    .pll_en_o      (pllEn),
    .link_en_o     (linkEn),
    .busy_o        (busy),
    .done_o        (done),
    .reg_timeout_o (regTo),
    .pll_timeout_o (pllTo)
  );

  typedef struct packed { int p; int dR; int dL; } vec_t;
  // poll interval, cycles until ready bit, cycles until lock bit
  localparam vec_t VECS [6] = '{
    '{3, 0, 0},
    '{1, 5, 2},
    '{2, NEVER, 1},
    '{4, 9, 0},
    '{3, 4, NEVER},
    '{0, 2, 7}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic powerDown();
    pdown = 1'b1;
    tick();
    pdown = 1'b0;
    chk(!regEn && !bgEn && !pllEn && !linkEn && !done && !busy,
        "R10 enables cleared by power-down", {regEn, bgEn, pllEn, linkEn, done, busy}, 0);
  endtask

  task automatic startSeq(input int p);
    pollCycles = 16'(p);
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(regEn && bgEn && busy && !regTo && !pllTo && !done,
        "R2/R8 start step", {regEn, bgEn, busy, regTo, pllTo, done}, 6'b111000);
  endtask

  function automatic int firstPoll(input int pe, input int d);
    int e;
    e = ((d + pe) / pe) * pe;
    return (e > MAXP * pe) ? MAXP * pe : e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    chk({regEn, bgEn, pllEn, linkEn, busy, done, regTo, pllTo} == '0,
        "R1 outputs in reset", {regEn, bgEn, pllEn, linkEn, busy, done, regTo, pllTo}, 0);
    rst_n = 1'b1;
    tick();
    chk({regEn, bgEn, pllEn, linkEn, busy, done, regTo, pllTo} == '0,
        "R1 outputs after reset", {regEn, bgEn, pllEn, linkEn, busy, done, regTo, pllTo}, 0);

    begin
      bit prevRegTo = 1'b0;
      bit prevPllTo = 1'b0;
      for (int v = 0; v < 6; v++) begin
        int pe, eR, eL, gotR, gotL, i, j;
        bit toR, toL;
        powerDown();
        chk(regTo == prevRegTo && pllTo == prevPllTo, "R8 flags survive power-down",
            {regTo, pllTo}, {prevRegTo, prevPllTo});
        status = '0;
        startSeq(VECS[v].p);
        pe  = (VECS[v].p == 0) ? 1 : VECS[v].p;
        eR  = firstPoll(pe, VECS[v].dR);
        toR = (VECS[v].dR + 1 > MAXP * pe);
        eL  = firstPoll(pe, VECS[v].dL);
        toL = (VECS[v].dL + 1 > MAXP * pe);
        i = 0; gotR = -1;
        while (i < MAXP * pe + 5 && gotR < 0) begin
          status[12] = (i >= VECS[v].dR);
          tick();
          i++;
          if (pllEn) gotR = i;
        end
        chk(gotR == eR, toR ? "R6 pll enable edge after timeout" : "R3 pll enable edge", gotR, eR);
        chk(regTo == toR && !linkEn, "R6 regulator timeout flag", regTo, toR);
        j = 0; gotL = -1;
        while (j < MAXP * pe + 5 && gotL < 0) begin
          status[8] = (j >= VECS[v].dL);
          tick();
          j++;
          if (linkEn) gotL = j;
        end
        chk(gotL == eL, toL ? "R7 link enable edge after timeout" : "R5 link enable edge", gotL, eL);
        chk(pllTo == toL && done && !busy, "R7 pll timeout flag and done", {pllTo, done, busy}, {toL, 2'b10});
        status = '0;
        repeat (5) tick();
        chk(regEn && bgEn && pllEn && linkEn && done && regTo == toR && pllTo == toL,
            "R11 enables held after completion", {regEn, bgEn, pllEn, linkEn, done}, 5'b11111);
        prevRegTo = toR;
        prevPllTo = toL;
      end
    end

    // R4: ready pulse between polls ignored, lock bit ignored in regulator stage
    begin
      int i, got;
      powerDown();
      status = 16'h0100;
      startSeq(4);
      i = 0; got = -1;
      while (i < 20 && got < 0) begin
        status[12] = (i == 1) || (i >= 5);
        tick();
        i++;
        if (pllEn) got = i;
      end
      chk(got == 8, "R4 off-poll ready pulse ignored", got, 8);
    end

    // R9: start while busy ignored
    begin
      int i, got;
      powerDown();
      status = 16'h1100;
      startSeq(3);
      i = 0; got = -1;
      while (i < 20 && got < 0) begin
        start = (i == 1);
        tick();
        i++;
        if (pllEn) got = i;
      end
      start = 1'b0;
      chk(got == 3, "R9 restart while busy ignored", got, 3);
      repeat (3) tick();
      chk(linkEn && done && !busy, "R9 sequence completed normally", {linkEn, done, busy}, 3'b110);
    end

    // R10: power-down wins over a simultaneous start
    pdown = 1'b1;
    start = 1'b1;
    tick();
    pdown = 1'b0;
    start = 1'b0;
    chk(!busy && !regEn && !bgEn && !pllEn && !linkEn && !done,
        "R10 power-down priority over start", {busy, regEn, pllEn, linkEn, done}, 0);
    tick();
    chk(!busy && !regEn, "R10 stays idle after power-down", {busy, regEn}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule